// File: doc/BRIEF.md
# UART Interrupt Status and Clear Logic

This block gathers the interrupt causes of a UART into one 32-bit status word and raises a single interrupt request line. Seven causes are single-cycle event pulses from the neighbouring logic: modem CTS change, transmit holding register empty, receive timeout, character received (wake-up), auto-baud done and auto-baud timeout, and receive overrun. Each event latches a status bit. Software clears that bit by writing a 1 to the same position of a write-only clear register.

Three receive error bits work differently. Break, framing error and parity error describe the character at the head of the receive buffer. They are computed from the head character's data, stop bit and parity result. They are cleared only when the receive buffer is popped, and they are reloaded from the new head one cycle later. A break is a frame in which every data bit and the stop bit are 0.

The request line is the OR of the status bits gated by a per-bit enable vector. It is registered. A two-stage synchronizer releases the asynchronous active-low reset on a clock edge. Every result below counts from the cycle in which that synchronized reset is high.

Top module: `uart_irq_status`

## Requirements
- R1: After reset every status bit reads 0 and `irq` is 0.
- R2: An event pulse sets its status bit on the next clock edge. The bit positions are: CTS change at bit 0, transmit empty at bit 4, receive timeout at bit 5, wake-up at bit 7, auto-baud done at bit 8, auto-baud timeout at bit 9, overrun at bit 15.
- R3: A write to offset 0x08 clears every event bit whose write-data bit is 1. Write-data bits that are 0, write-data bits outside {0,4,5,7,8,9,15}, and writes to any other offset leave the status unchanged.
- R4: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit stays set.
- R5: Bit 12 (break) is 1 when the head character is valid and both its data and its stop bit are all zero.
- R6: Bit 13 (framing) is 1 when the valid head character has a 0 stop bit, whether or not its data is zero.
- R7: Bit 14 (parity) is 1 only when parity checking is enabled and the head character failed parity.
- R8: Bits 12 to 14 are not affected by the clear register. A pop clears them on its clock edge. One edge later they hold the new head's flags, or 0 if the buffer is empty.
- R9: Bit 15 (overrun) is not cleared by a pop. Only the clear register clears it.
- R10: A read at offset 0x00 returns the status word, with bits 1 to 3, 6, 10, 11 and 31:16 reading 0. A read at any other offset returns 0.
- R11: `irq` equals the OR of status bits 15:0 ANDed with `irq_en`, delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cts_chg | input | 1 | Modem CTS change pulse |
| ev_thr_empty | input | 1 | Transmit holding register empty pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_rx_char | input | 1 | Character received pulse (wake-up) |
| ev_abaud_done | input | 1 | Auto-baud complete pulse |
| ev_abaud_tmo | input | 1 | Auto-baud timeout pulse |
| ev_overrun | input | 1 | Receive character lost pulse |
| rx_pop | input | 1 | Receive buffer pop strobe |
| head_valid | input | 1 | Receive buffer head holds a character |
| head_data | input | DATA_W | Data bits of the head character |
| head_stop | input | 1 | Sampled stop bit of the head character |
| head_par_fail | input | 1 | Head character failed its parity check |
| parity_en | input | 1 | Parity checking enabled |
| irq_en | input | 16 | Per-bit interrupt enables for status bits 15:0 |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Registered interrupt request |

## Verification
The event path is driven one cause at a time to confirm each bit position. All causes are then driven together and cleared with zero data, with reserved-only data, with a single bit and through the wrong offset. This separates a wrong bit map from a decode that clears too much or too little. The receive error path gets an all-zero frame, a framing-only frame, a parity failure with checking off and then on, and pops that leave the buffer filled or empty. These cases tell a break apart from a framing error, and a reload apart from a plain clear. The same-cycle set and clear, a pop with overrun pending, and the one-edge lag of the request line with its enable mask cover the ordering cases.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned ST_W  = 32;
  localparam int unsigned EN_W  = 16;
  localparam int unsigned N_EVT = 7;

  localparam int unsigned B_BRK = 12;
  localparam int unsigned B_FRM = 13;
  localparam int unsigned B_PAR = 14;

  localparam logic [ST_W-1:0] W1C_MASK = 32'h0000_83B1;

  // position of event index i in the status word
  function automatic int unsigned evt_pos(input int unsigned i);
    case (i)
      0:       evt_pos = 0;   // CTS change
      1:       evt_pos = 4;   // transmit empty
      2:       evt_pos = 5;   // receive timeout
      3:       evt_pos = 7;   // wake-up
      4:       evt_pos = 8;   // auto-baud done
      5:       evt_pos = 9;   // auto-baud timeout
      default: evt_pos = 15;  // overrun
    endcase
  endfunction

  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rx_err_t;
endpackage

// File: rtl/uart_irq_evt_bits.sv
module uart_irq_evt_bits #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  logic [N-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    for (int i = 0; i < int'(N); i++) begin
      if (set_i[i])      bits_d[i] = 1'b1;   // set beats clear
      else if (clr_i[i]) bits_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  for (genvar g = 0; g < int'(N); g++) begin : g_chk
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> bits_q[g]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !bits_q[g]);
  end
endmodule

// File: rtl/uart_irq_rx_err.sv
module uart_irq_rx_err
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pop,
  input  logic              head_valid,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_stop,
  input  logic              head_par_fail,
  input  logic              parity_en,
  output rx_err_t           err_o
);
  rx_err_t err_q, err_d, head_flags;
  logic    reload_q, reload_d;
  logic    valid_q;
  logic    load;

  always_comb begin
    head_flags.brk = head_valid && (head_data == '0) && !head_stop;
    head_flags.frm = head_valid && !head_stop;
    head_flags.par = head_valid && parity_en && head_par_fail;
  end

  assign load = reload_q || (head_valid && !valid_q);

  always_comb begin
    err_d    = err_q;
    reload_d = 1'b0;
    if (rx_pop) begin
      err_d    = '0;
      reload_d = 1'b1;
    end else if (load) begin
      err_d = head_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      reload_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      err_q    <= err_d;
      reload_q <= reload_d;
      valid_q  <= head_valid;
    end
  end

  assign err_o = err_q;

  assert_pop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> (err_q == '0));
  assert_parity_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q.par) |-> $past(parity_en));
  assert_break_is_framing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q.brk |-> err_q.frm);
endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] status_i,
  input  logic [EN_W-1:0] en_i,
  output logic            irq_o
);
  logic irq_q, irq_d;

  assign irq_d = |(status_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(|(status_i & en_i))));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cts_chg,
  input  logic              ev_thr_empty,
  input  logic              ev_rx_timeout,
  input  logic              ev_rx_char,
  input  logic              ev_abaud_done,
  input  logic              ev_abaud_tmo,
  input  logic              ev_overrun,
  input  logic              rx_pop,
  input  logic              head_valid,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_stop,
  input  logic              head_par_fail,
  input  logic              parity_en,
  input  logic [15:0]       irq_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             clr_wr;
  logic [N_EVT-1:0] evt_set, evt_clr, evt_q;
  rx_err_t          err;
  logic [ST_W-1:0]  status;

  assign clr_wr  = bus_wr && (bus_addr == OFF_CLR);
  assign evt_set = {ev_overrun, ev_abaud_tmo, ev_abaud_done, ev_rx_char,
                    ev_rx_timeout, ev_thr_empty, ev_cts_chg};

  for (genvar g = 0; g < int'(N_EVT); g++) begin : g_clr
    assign evt_clr[g] = clr_wr && bus_wdata[evt_pos(g)];
  end

  uart_irq_evt_bits #(.N(N_EVT)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .bits_o (evt_q)
  );

  uart_irq_rx_err #(.DATA_W(DATA_W)) u_rxerr (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .rx_pop        (rx_pop),
    .head_valid    (head_valid),
    .head_data     (head_data),
    .head_stop     (head_stop),
    .head_par_fail (head_par_fail),
    .parity_en     (parity_en),
    .err_o         (err)
  );

  always_comb begin
    status = '0;
    for (int i = 0; i < int'(N_EVT); i++) status[evt_pos(i)] = evt_q[i];
    status[B_BRK] = err.brk;
    status[B_FRM] = err.frm;
    status[B_PAR] = err.par;
  end

  assign bus_rdata = (bus_rd && (bus_addr == OFF_STAT)) ? status : '0;

  uart_irq_req u_req (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .status_i (status[EN_W-1:0]),
    .en_i     (irq_en),
    .irq_o    (irq)
  );

  // event bits never fall unless a real clear bit was written
  assert_rsvd_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(clr_wr && ((bus_wdata & W1C_MASK) != '0)) |=> ((~evt_q & $past(evt_q)) == '0));
  assert_overrun_survives_pop_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (status[15] && rx_pop && !(clr_wr && bus_wdata[15])) |=> status[15]);
endmodule

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        rx_pop = 1'b0, head_valid = 1'b0, head_stop = 1'b0;
  logic        head_par_fail = 1'b0, parity_en = 1'b0;
  logic [7:0]  head_data = '0;
  logic [15:0] irq_en = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int pos [7] = '{0, 4, 5, 7, 8, 9, 15};

  always #4 clk = ~clk;  // 125 MHz

  uart_irq_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_cts_chg(evt[0]), .ev_thr_empty(evt[1]), .ev_rx_timeout(evt[2]),
    .ev_rx_char(evt[3]), .ev_abaud_done(evt[4]), .ev_abaud_tmo(evt[5]),
    .ev_overrun(evt[6]),
    .rx_pop(rx_pop), .head_valid(head_valid), .head_data(head_data),
    .head_stop(head_stop), .head_par_fail(head_par_fail), .parity_en(parity_en),
    .irq_en(irq_en), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic pop(input logic keep_valid);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0; head_valid = keep_valid;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d, exp;
    exp = '0;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1) << i);
      exp |= 32'(1) << pos[i];
      rd(8'h00, d); chk("R2 event bit position", d, exp);
    end
    wr(8'h08, 32'h0000_83B1);
    rd(8'h00, d); chk("R3 clear all event bits", d, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    pulse(7'h7F);
    rd(8'h00, d); chk("R2 all events together", d, 32'h0000_83B1);
    wr(8'h08, 32'h0);
    rd(8'h00, d); chk("R3 zero write no effect", d, 32'h0000_83B1);
    wr(8'h08, ~32'h0000_83B1);
    rd(8'h00, d); chk("R3 reserved clear bits ignored", d, 32'h0000_83B1);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R3 write to status offset ignored", d, 32'h0000_83B1);
    wr(8'h08, 32'h0000_0080);
    rd(8'h00, d); chk("R3 single bit clear", d, 32'h0000_8331);
    wr(8'h08, 32'h0000_83B1);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); evt = 7'h40; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h8000;
    @(negedge clk); evt = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rd(8'h00, d); chk("R4 set beats same-cycle clear", d, 32'h0000_8000);
    wr(8'h08, 32'h8000);
    rd(8'h00, d); chk("R3 overrun cleared afterwards", d, 32'h0);
  endtask

  task automatic t_rx_err();
    logic [31:0] d;
    @(negedge clk); head_valid = 1'b1; head_data = 8'h00; head_stop = 1'b0;
    head_par_fail = 1'b1; parity_en = 1'b0;
    @(negedge clk);
    rd(8'h00, d); chk("R5 R6 R7 break frame, parity off", d, 32'h0000_3000);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R8 clear register keeps error bits", d, 32'h0000_3000);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0; head_data = 8'h55; head_stop = 1'b1;
    head_par_fail = 1'b1; parity_en = 1'b1;
    rd(8'h00, d); chk("R8 pop clears error bits", d, 32'h0);
    @(negedge clk);
    rd(8'h00, d); chk("R7 R8 new head parity error", d, 32'h0000_4000);
    pop(1'b0);
    @(negedge clk);
    rd(8'h00, d); chk("R8 empty after pop", d, 32'h0);
    @(negedge clk); head_valid = 1'b1; head_data = 8'h41; head_stop = 1'b0;
    head_par_fail = 1'b0;
    @(negedge clk);
    rd(8'h00, d); chk("R6 framing without break", d, 32'h0000_2000);
    pop(1'b0);
    @(negedge clk);
    parity_en = 1'b0; head_stop = 1'b1; head_data = '0;
  endtask

  task automatic t_ovr_pop();
    logic [31:0] d;
    pulse(7'h40);
    pop(1'b0);
    rd(8'h00, d); chk("R9 overrun survives pop", d, 32'h0000_8000);
    wr(8'h08, 32'h8000);
    rd(8'h00, d); chk("R9 overrun cleared by register", d, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    pulse(7'h08);
    rd(8'h04, d); chk("R10 other offset reads 0", d, 32'h0);
    rd(8'h00, d); chk("R10 reserved bits read 0", d, 32'h0000_0080);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_en = 16'h0001;
    @(negedge clk); chk("R11 masked source no irq", {31'h0, irq}, 32'h0);
    irq_en = 16'h0080;
    #1 chk("R11 irq not yet high", {31'h0, irq}, 32'h0);
    @(negedge clk); chk("R11 irq high one edge later", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h0080);
    chk("R11 irq lags the clear", {31'h0, irq}, 32'h1);
    @(negedge clk); chk("R11 irq low after clear", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_events();
    t_ignore();
    t_set_wins();
    t_rx_err();
    t_ovr_pop();
    t_read();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule